// File: doc/BRIEF.md
# Clock Generator Power-Down and Suspend Controller

This block sits beside the PLLs and output dividers of a multi-PLL clock generator. It turns two slow board-level control pins into the enable signals those circuits need. One pin is active-low and serves as shutdown/output-enable. The other is the top bit of the frequency-select pins, which can also serve as an active-low suspend input. From these pins the block drives a run enable for each PLL, an enable for the reference oscillator, and a drive enable for each clock output (low means tristate). Configuration bits set the behaviour:
- whether the shutdown pin also powers the chip down or only gates the outputs;
- whether the select bit acts as a suspend input;
- which PLLs and which outputs a suspend turns off;
- which source feeds each output.

When the block returns from a full shutdown, it holds the outputs in tristate while the PLLs relock. The wait ends when every PLL that should be running reports lock, or when a programmable cycle timer runs out, whichever comes first. If the suspend masks would leave an output enabled while its PLL is stopped, the block suspends that output anyway and sets a sticky error flag. The frequency-select value passed on to the divider logic has the suspend bit forced to zero while that bit serves as the suspend input.

Top module: `clkgen_pwr_ctrl`

## Requirements
- R1: A low level on `oe_shdn_n` drives `out_en` to all zeros from the third rising clock edge after the pin changes. `out_en` is unchanged at the second edge.
- R2: With `cfg_shdn_en`=1, a low `oe_shdn_n` also drives `pll_run` to all zeros and `osc_run` to 0 at the third edge. With `cfg_shdn_en`=0, the PLLs and the oscillator keep running and the pin gates only the outputs, which come back at the third edge after the pin returns high.
- R3: When `oe_shdn_n` returns high after a full shutdown, `relocking` goes to 1 and the PLLs run again at the third edge. If lock is never reported, `out_en` stays at zero until edge 4+P, where P is `cfg_relock_preset`.
- R4: During relock, the wait ends as soon as every PLL that is not suspended reports lock. With lock already present, `out_en` returns at the fourth edge.
- R5: A new shutdown during the relock wait cancels the wait. The next return from shutdown restarts the full P-cycle wait.
- R6: With `cfg_susp_en`=1 and `sel_pins[2]` low, the PLLs set in `cfg_pll_susp` stop and the outputs set in `cfg_out_susp` go to tristate at the third edge. All other PLLs and outputs are unaffected, and they resume when the pin goes high.
- R7: With `cfg_susp_en`=0, `sel_pins[2]` has no effect on any enable. `freq_sel` follows all three select pins with a three-edge delay.
- R8: With `cfg_susp_en`=1, `freq_sel[2]` is 0 and `freq_sel[1:0]` follows `sel_pins[1:0]`.
- R9: Output j takes its source from the 2-bit field `cfg_route[2j+1:2j]`. Code 0 is the reference, and code k (1..3) is PLL k-1. If an output's source PLL is in the suspend mask, the block suspends that output even when its own mask bit is clear. Such a configuration with suspend enabled sets `cfg_err`, which stays 1 until reset.
- R10: During reset, all enables, `freq_sel`, `relocking` and `cfg_err` are 0.
- R11: An output routed to the reference (code 0) is never suspended by the PLL suspend mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_shdn_n | input | 1 | Asynchronous active-low shutdown / output-enable pin |
| sel_pins | input | 3 | Asynchronous frequency-select pins; bit 2 doubles as active-low suspend |
| pll_locked | input | 3 | Lock indication from each PLL |
| cfg_shdn_en | input | 1 | 1: low pin powers the chip down; 0: the pin gates only the outputs |
| cfg_susp_en | input | 1 | 1: select bit 2 acts as the suspend input |
| cfg_pll_susp | input | 3 | PLLs stopped during suspend |
| cfg_out_susp | input | 4 | Outputs tristated during suspend |
| cfg_route | input | 8 | Per-output source code, 2 bits each |
| cfg_relock_preset | input | 16 | Relock timeout in clock cycles |
| pll_run | output | 3 | Per-PLL run enable |
| osc_run | output | 1 | Reference oscillator enable |
| out_en | output | 4 | Per-output drive enable (0 = tristate) |
| freq_sel | output | 3 | Synchronized select index for the frequency-select logic |
| relocking | output | 1 | High while waiting for relock after shutdown |
| cfg_err | output | 1 | Sticky flag for a suspend configuration that breaks the derived-output rule |

## Verification
A corrupted relock counter or state register shows up at `out_en`. The outputs either return before edge 4+P or stay off after it, so the edge at which `out_en` rises is checked to the cycle. Errors in the suspend-mask resolution show up as an enabled output whose source PLL has `pll_run` low, or as a reference-fed output that is wrongly off. These appear three edges after the select pin moves. A lost sticky error appears at `cfg_err` on the first cycle after the bad configuration is corrected.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;

    // Power sequencing phases
    typedef enum logic [1:0] {
        PS_HALT   = 2'd0,
        PS_RELOCK = 2'd1,
        PS_RUN    = 2'd2
    } pwr_state_e;

    // Decoded pin intent after synchronization
    typedef struct packed {
        logic oe;        // output-enable level (1 = drive)
        logic shutdown;  // full power-down requested
        logic suspend;   // suspend requested
    } pin_ctl_t;

    // True when route code selects PLL index pll (code 0 = reference)
    function automatic logic src_hits_pll(input int unsigned code, input int unsigned pll);
        return code == (pll + 1);
    endfunction

endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[b] <= 1'b0;
                stage2[b] <= 1'b0;
            end else begin
                stage1[b] <= d[b];
                stage2[b] <= stage1[b];
            end
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pwr_susp_resolve.sv
module pwr_susp_resolve
    import pwr_ctrl_pkg::*;
#(
    parameter int NUM_PLL = 3,
    parameter int NUM_OUT = 4,
    parameter int SRC_W   = 2
) (
    input  logic [NUM_PLL-1:0]       pll_mask,
    input  logic [NUM_OUT-1:0]       out_mask,
    input  logic [NUM_OUT*SRC_W-1:0] route,
    output logic [NUM_OUT-1:0]       eff_out_mask,
    output logic                     violation
);
    logic [NUM_PLL-1:0] hit [NUM_OUT];
    logic [NUM_OUT-1:0] forced;

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
        for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
            assign hit[j][i] = pll_mask[i] &
                src_hits_pll(int'(route[j*SRC_W +: SRC_W]), i);
        end
        assign forced[j] = |hit[j];
    end

    assign eff_out_mask = out_mask | forced;
    assign violation    = |(forced & ~out_mask);
endmodule

// File: rtl/pwr_relock_fsm.sv
module pwr_relock_fsm
    import pwr_ctrl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shutdown,
    input  logic             all_locked,
    input  logic [CNT_W-1:0] preset,
    output pwr_state_e       state_nxt,
    output pwr_state_e       state_q
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            PS_HALT:   if (!shutdown) state_nxt = PS_RELOCK;
            PS_RELOCK: begin
                if (shutdown)                         state_nxt = PS_HALT;
                else if (all_locked || cnt == '0)     state_nxt = PS_RUN;
            end
            PS_RUN:    if (shutdown) state_nxt = PS_HALT;
            default:   state_nxt = PS_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_HALT;
            cnt     <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_q == PS_HALT || state_nxt == PS_HALT)
                cnt <= preset;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/clkgen_pwr_ctrl.sv
module clkgen_pwr_ctrl
    import pwr_ctrl_pkg::*;
#(
    parameter int NUM_PLL = 3,
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = 3,
    parameter int CNT_W   = 16,
    localparam int SRC_W  = $clog2(NUM_PLL + 1),
    localparam int RT_W   = NUM_OUT * SRC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               oe_shdn_n,
    input  logic [SEL_W-1:0]   sel_pins,
    input  logic [NUM_PLL-1:0] pll_locked,
    input  logic               cfg_shdn_en,
    input  logic               cfg_susp_en,
    input  logic [NUM_PLL-1:0] cfg_pll_susp,
    input  logic [NUM_OUT-1:0] cfg_out_susp,
    input  logic [RT_W-1:0]    cfg_route,
    input  logic [CNT_W-1:0]   cfg_relock_preset,
    output logic [NUM_PLL-1:0] pll_run,
    output logic               osc_run,
    output logic [NUM_OUT-1:0] out_en,
    output logic [SEL_W-1:0]   freq_sel,
    output logic               relocking,
    output logic               cfg_err
);
    localparam int SUSP_BIT = SEL_W - 1;

    logic [SEL_W:0]     pins_s;
    logic [SEL_W-1:0]   sel_s;
    pin_ctl_t           ctl;
    logic [NUM_PLL-1:0] want_run;
    logic               all_locked;
    logic [NUM_OUT-1:0] eff_mask;
    logic               viol;
    pwr_state_e         st_nxt;
    pwr_state_e         st_q;

    logic [NUM_PLL-1:0] pll_run_d;
    logic [NUM_OUT-1:0] out_en_d;
    logic [SEL_W-1:0]   freq_d;

    pwr_pin_sync #(.W(SEL_W + 1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({oe_shdn_n, sel_pins}),
        .q   (pins_s)
    );

    assign sel_s        = pins_s[SEL_W-1:0];
    assign ctl.oe       = pins_s[SEL_W];
    assign ctl.shutdown = cfg_shdn_en & ~pins_s[SEL_W];
    assign ctl.suspend  = cfg_susp_en & ~sel_s[SUSP_BIT];

    pwr_susp_resolve #(
        .NUM_PLL (NUM_PLL),
        .NUM_OUT (NUM_OUT),
        .SRC_W   (SRC_W)
    ) u_resolve (
        .pll_mask     (cfg_pll_susp),
        .out_mask     (cfg_out_susp),
        .route        (cfg_route),
        .eff_out_mask (eff_mask),
        .violation    (viol)
    );

    assign want_run   = ~({NUM_PLL{ctl.suspend}} & cfg_pll_susp);
    assign all_locked = &(pll_locked | ~want_run);

    pwr_relock_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .shutdown   (ctl.shutdown),
        .all_locked (all_locked),
        .preset     (cfg_relock_preset),
        .state_nxt  (st_nxt),
        .state_q    (st_q)
    );

    always_comb begin
        pll_run_d = (st_nxt == PS_HALT) ? '0 : want_run;
        if (ctl.oe && st_nxt == PS_RUN)
            out_en_d = ~({NUM_OUT{ctl.suspend}} & eff_mask);
        else
            out_en_d = '0;
        freq_d = sel_s;
        if (cfg_susp_en)
            freq_d[SUSP_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pll_run   <= '0;
            osc_run   <= 1'b0;
            out_en    <= '0;
            freq_sel  <= '0;
            relocking <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            pll_run   <= pll_run_d;
            osc_run   <= (st_nxt != PS_HALT);
            out_en    <= out_en_d;
            freq_sel  <= freq_d;
            relocking <= (st_nxt == PS_RELOCK);
            cfg_err   <= cfg_err | (cfg_susp_en & viol);
        end
    end
endmodule

// File: rtl/pwr_ctrl_chk.sv
module pwr_ctrl_chk #(
    parameter int NUM_PLL = 3,
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = 3,
    parameter int SRC_W   = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     oe_shdn_n,
    input logic                     cfg_shdn_en,
    input logic                     cfg_susp_en,
    input logic [NUM_OUT*SRC_W-1:0] cfg_route,
    input logic [NUM_PLL-1:0]       pll_run,
    input logic                     osc_run,
    input logic [NUM_OUT-1:0]       out_en,
    input logic [SEL_W-1:0]         freq_sel,
    input logic                     relocking,
    input logic                     cfg_err
);
    logic [1:0] since;
    always_ff @(posedge clk) begin
        if (rst)                since <= 2'd0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    // R1
    pin_low_tristates_chk: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && !$past(oe_shdn_n, 3)) |-> (out_en == '0));

    // R2
    shutdown_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && !$past(oe_shdn_n, 3) && $past(cfg_shdn_en))
            |-> (pll_run == '0 && !osc_run));

    // R3
    relock_holds_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        relocking |-> (out_en == '0));

    // R8
    susp_bit_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (since != 2'd0 && $past(cfg_susp_en)) |-> !freq_sel[SEL_W-1]);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (since != 2'd0 && $past(cfg_err)) |-> cfg_err);

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_o
        for (genvar i = 0; i < NUM_PLL; i++) begin : g_p
            // R9
            derived_src_runs_chk: assert property (@(posedge clk) disable iff (rst)
                (since != 2'd0 && out_en[j] &&
                 $past(cfg_route[j*SRC_W +: SRC_W]) == SRC_W'(i + 1))
                    |-> pll_run[i]);
        end
    end
endmodule

bind clkgen_pwr_ctrl pwr_ctrl_chk #(
    .NUM_PLL (NUM_PLL),
    .NUM_OUT (NUM_OUT),
    .SEL_W   (SEL_W),
    .SRC_W   (SRC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .oe_shdn_n   (oe_shdn_n),
    .cfg_shdn_en (cfg_shdn_en),
    .cfg_susp_en (cfg_susp_en),
    .cfg_route   (cfg_route),
    .pll_run     (pll_run),
    .osc_run     (osc_run),
    .out_en      (out_en),
    .freq_sel    (freq_sel),
    .relocking   (relocking),
    .cfg_err     (cfg_err)
);

// File: tb/sim_clkgen_pwr_ctrl.sv
module sim_clkgen_pwr_ctrl;
    localparam int P = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        oe_shdn_n;
    logic [2:0]  sel_pins;
    logic [2:0]  pll_locked;
    logic        cfg_shdn_en, cfg_susp_en;
    logic [2:0]  cfg_pll_susp;
    logic [3:0]  cfg_out_susp;
    logic [7:0]  cfg_route;
    logic [15:0] cfg_relock_preset;
    logic [2:0]  pll_run;
    logic        osc_run;
    logic [3:0]  out_en;
    logic [2:0]  freq_sel;
    logic        relocking;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    logic err_m = 1'b0;

    always #2 clk = ~clk;

    clkgen_pwr_ctrl u0 (
        .clk (clk), .rst (rst), .oe_shdn_n (oe_shdn_n), .sel_pins (sel_pins),
        .pll_locked (pll_locked), .cfg_shdn_en (cfg_shdn_en), .cfg_susp_en (cfg_susp_en),
        .cfg_pll_susp (cfg_pll_susp), .cfg_out_susp (cfg_out_susp), .cfg_route (cfg_route),
        .cfg_relock_preset (cfg_relock_preset), .pll_run (pll_run), .osc_run (osc_run),
        .out_en (out_en), .freq_sel (freq_sel), .relocking (relocking), .cfg_err (cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive_oe(input logic v);
        @(negedge clk);
        oe_shdn_n = v;
    endtask

    // Expected steady-state outputs from the requirements
    function automatic void model(
        input  logic oe, input logic [2:0] sel, input logic shdn_en, input logic susp_en,
        input  logic [2:0] pm, input logic [3:0] om, input logic [7:0] rt,
        output logic [3:0] oen, output logic [2:0] prun, output logic orun,
        output logic [2:0] fs, output logic viol);
        logic susp, shdn;
        logic [3:0] eff;
        susp = susp_en & ~sel[2];
        shdn = shdn_en & ~oe;
        eff  = om;
        viol = 1'b0;
        for (int j = 0; j < 4; j++) begin
            int code = int'(rt[2*j +: 2]);
            if (code != 0 && pm[code-1]) begin
                eff[j] = 1'b1;
                if (!om[j]) viol = 1'b1;
            end
        end
        for (int i = 0; i < 3; i++) prun[i] = !shdn && !(susp && pm[i]);
        orun = !shdn;
        for (int j = 0; j < 4; j++) oen[j] = oe && !shdn && !(susp && eff[j]);
        fs = susp_en ? {1'b0, sel[1:0]} : sel;
    endfunction

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] e_oen;
        logic [2:0] e_prun, e_fs;
        logic e_orun, e_viol;
        void'($urandom(32'd7321));
        rst = 1'b1; oe_shdn_n = 1'b0; sel_pins = 3'b000; pll_locked = 3'b111;
        cfg_shdn_en = 1'b1; cfg_susp_en = 1'b0; cfg_pll_susp = '0; cfg_out_susp = '0;
        cfg_route = 8'b10_00_10_01; cfg_relock_preset = 16'(P);
        edges(5);
        // R10 reset state
        chk("R10 out_en", 32'(out_en), 0);
        chk("R10 pll_run", 32'(pll_run), 0);
        chk("R10 osc_run", 32'(osc_run), 0);
        chk("R10 cfg_err", 32'(cfg_err), 0);
        chk("R10 relocking", 32'(relocking), 0);
        chk("R10 freq_sel", 32'(freq_sel), 0);
        @(negedge clk); rst = 1'b0; oe_shdn_n = 1'b1;
        edges(10);
        chk("R4 powerup out_en", 32'(out_en), 32'hF);

        // R1 latency and R2 full shutdown
        drive_oe(1'b0);
        edges(2);
        chk("R1 second edge out_en", 32'(out_en), 32'hF);
        edges(1);
        chk("R1 out_en", 32'(out_en), 0);
        chk("R2 pll_run", 32'(pll_run), 0);
        chk("R2 osc_run", 32'(osc_run), 0);

        // R4 early exit with lock present
        drive_oe(1'b1);
        edges(3);
        chk("R3 out_en held", 32'(out_en), 0);
        chk("R3 relocking", 32'(relocking), 1);
        chk("R3 pll_run", 32'(pll_run), 32'h7);
        edges(1);
        chk("R4 out_en", 32'(out_en), 32'hF);
        chk("R4 relocking", 32'(relocking), 0);

        // R3 timer expiry without lock
        pll_locked = 3'b000;
        drive_oe(1'b0); edges(6);
        drive_oe(1'b1);
        edges(3 + P);
        chk("R3 before timeout", 32'(out_en), 0);
        edges(1);
        chk("R3 at timeout", 32'(out_en), 32'hF);

        // R5 restart on re-shutdown
        drive_oe(1'b0); edges(6);
        drive_oe(1'b1); edges(10);
        drive_oe(1'b0); edges(6);
        chk("R5 halted pll_run", 32'(pll_run), 0);
        drive_oe(1'b1);
        edges(3 + P);
        chk("R5 before restarted timeout", 32'(out_en), 0);
        edges(1);
        chk("R5 at restarted timeout", 32'(out_en), 32'hF);
        pll_locked = 3'b111;

        // R2 output-enable-only mode
        @(negedge clk); cfg_shdn_en = 1'b0;
        drive_oe(1'b0); edges(3);
        chk("R2 oe-only out_en", 32'(out_en), 0);
        chk("R2 oe-only pll_run", 32'(pll_run), 32'h7);
        chk("R2 oe-only osc_run", 32'(osc_run), 1);
        drive_oe(1'b1); edges(3);
        chk("R2 oe-only return", 32'(out_en), 32'hF);

        // R6 suspend with a valid mask
        @(negedge clk); cfg_susp_en = 1'b1; cfg_pll_susp = 3'b010; cfg_out_susp = 4'b1010;
        sel_pins = 3'b011;
        edges(3);
        chk("R6 pll_run", 32'(pll_run), 32'h5);
        chk("R6 out_en", 32'(out_en), 32'h5);
        chk("R6 cfg_err", 32'(cfg_err), 0);
        @(negedge clk); sel_pins = 3'b111;
        edges(3);
        chk("R6 resume out_en", 32'(out_en), 32'hF);
        chk("R8 freq_sel", 32'(freq_sel), 32'h3);

        // R7 suspend disabled
        @(negedge clk); cfg_susp_en = 1'b0; sel_pins = 3'b011;
        edges(3);
        chk("R7 out_en", 32'(out_en), 32'hF);
        chk("R7 pll_run", 32'(pll_run), 32'h7);
        chk("R7 freq_sel", 32'(freq_sel), 32'h3);
        @(negedge clk); sel_pins = 3'b100;
        edges(3);
        chk("R7 freq_sel msb", 32'(freq_sel), 32'h4);

        // R9 forced dependents and sticky error
        @(negedge clk); cfg_susp_en = 1'b1; cfg_out_susp = 4'b0000; sel_pins = 3'b011;
        edges(3);
        chk("R9 forced out_en", 32'(out_en), 32'h5);
        chk("R9 cfg_err set", 32'(cfg_err), 1);
        @(negedge clk); cfg_out_susp = 4'b1010;
        edges(3);
        chk("R9 cfg_err sticky", 32'(cfg_err), 1);

        // R11 reference-fed output survives full PLL suspend
        @(negedge clk); cfg_pll_susp = 3'b111; cfg_out_susp = 4'b1011;
        edges(3);
        chk("R11 out_en", 32'(out_en), 32'h4);
        chk("R11 pll_run", 32'(pll_run), 0);
        err_m = 1'b1;

        // Random mix
        for (int it = 0; it < 150; it++) begin
            @(negedge clk);
            oe_shdn_n    = ($urandom % 4) != 0;
            sel_pins     = 3'($urandom);
            cfg_shdn_en  = 1'($urandom);
            cfg_susp_en  = 1'($urandom);
            cfg_pll_susp = 3'($urandom);
            cfg_out_susp = 4'($urandom);
            cfg_route    = 8'($urandom);
            edges(8);
            model(oe_shdn_n, sel_pins, cfg_shdn_en, cfg_susp_en, cfg_pll_susp,
                  cfg_out_susp, cfg_route, e_oen, e_prun, e_orun, e_fs, e_viol);
            err_m = err_m | (cfg_susp_en & e_viol);
            chk("R1 R6 rand out_en", 32'(out_en), 32'(e_oen));
            chk("R2 R6 rand pll_run", 32'(pll_run), 32'(e_prun));
            chk("R2 rand osc_run", 32'(osc_run), 32'(e_orun));
            chk("R8 rand freq_sel", 32'(freq_sel), 32'(e_fs));
            chk("R9 rand cfg_err", 32'(cfg_err), 32'(err_m));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule